// File: doc/BRIEF.md
# Link error counters with thresholds

This block keeps three 16-bit tallies of link faults: symbol decode errors, frame CRC errors and handshake errors. The link layer reports each fault as a single-cycle pulse on its own input line, and the matching tally adds one. Each tally has a programmable 16-bit limit. When an increment brings a tally up to its limit, the block raises a one-cycle threshold event toward the interrupt unit.

Software reaches the six 16-bit registers through a halfword-addressed window. It can load any tally or limit directly. The usual start-up sequence loads every limit with 0x8000 and every tally with 0x0000, and software may clear a tally again at any time. Reads are combinational from a separate read address.

Top module: `link_err_counters`

## Requirements
- R1: After a synchronous active-low reset, every tally reads 0x0000, every limit reads 0x8000 and no threshold event is asserted.
- R2: The window sits at byte offset 0x040. The decode tally is at 0x040 and its limit at 0x042. The CRC tally is at 0x044 and its limit at 0x046. The handshake tally is at 0x048 and its limit at 0x04A. A write takes effect at the next clock edge. An odd address or an address outside 0x040..0x04B has no effect on a write and reads as 0x0000.
- R3: An error pulse on line i (bit 0 decode, bit 1 CRC, bit 2 handshake) increments tally i by exactly one, and the new value is readable after the next clock edge.
- R4: A tally at 0xFFFF stays at 0xFFFF when a further error pulse arrives.
- R5: When an increment makes tally i equal to its limit, event bit i is high for exactly the one cycle after that clock edge. Event bits 0, 1 and 2 (decode, CRC, handshake) feed interrupt bits 8, 9 and 10. A further increment past the limit raises no event.
- R6: A limit of 0x0000 never produces an event.
- R7: A software write to a tally in the same cycle as an error pulse on that tally wins: the tally takes the written value and no event is raised, even when the written value equals the limit.
- R8: An error pulse or register write aimed at one tally leaves the other tallies unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Byte address of the write |
| wr_data | input | 16 | Write data |
| rd_addr | input | 12 | Byte address of the read |
| rd_data | output | 16 | Read data (combinational) |
| err_pulse | input | 3 | Error pulses: bit 0 decode, bit 1 CRC, bit 2 handshake |
| thr_evt | output | 3 | Threshold events, same bit order |

## Verification
The hardest cases to reach from the ports are saturation and the event at the very top of the range. Reaching 0xFFFF by pulses alone would take 65535 cycles. The stimulus instead loads a tally with 0xFFFE through the write port and then pulses it, first with a zero limit and then with a limit of 0xFFFF. The table also pairs a tally write with an error pulse in the same cycle, and writes a tally directly to its limit value, to show that neither one raises an event.

// File: rtl/lec_pkg.sv
// Shared constants for the link error counter block.
// Assumes byte addressing with 16-bit registers on even addresses.
package lec_pkg;
    localparam int          LEC_CNT_W    = 16;
    localparam int          LEC_NUM      = 3;
    localparam int          LEC_ADDR_W   = 12;
    localparam logic [11:0] LEC_WIN_BASE = 12'h040;
    localparam logic [15:0] LEC_THR_RST  = 16'h8000;
endpackage

// File: rtl/lec_regdec.sv
// Register window decoder: turns a byte address into one-hot tally and
// limit selects. Each counter owns 4 bytes (tally, then limit).
// Assumes: odd addresses and addresses outside the window select nothing.
module lec_regdec #(
    parameter int                  NUM_CNT  = 3,
    parameter int                  ADDR_W   = 12,
    parameter logic [ADDR_W-1:0]   WIN_BASE = 12'h040
) (
    input  logic                 en,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_CNT-1:0]   cnt_sel,
    output logic [NUM_CNT-1:0]   thr_sel
);
    localparam int SPAN = 4 * NUM_CNT;

    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] slot;
    logic              in_win;

    // Offset inside the window and validity of the access
    always_comb begin
        off    = addr - WIN_BASE;
        slot   = off >> 2;
        in_win = en && (addr >= WIN_BASE) && (off < ADDR_W'(SPAN)) && !off[0];
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_sel
        assign cnt_sel[i] = in_win && !off[1] && (slot == ADDR_W'(i));
        assign thr_sel[i] = in_win &&  off[1] && (slot == ADDR_W'(i));
    end
endmodule

// File: rtl/lec_counter.sv
// One saturating error tally with its programmable limit and event.
// Assumes: a tally write beats a same-cycle error pulse; the event compares
// the incremented value with the limit held before the clock edge.
module lec_counter #(
    parameter int               CNT_W   = 16,
    parameter logic [CNT_W-1:0] THR_RST = 16'h8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic             thr_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             err,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] thr_q,
    output logic             evt
);
    logic [CNT_W-1:0] cnt_inc;
    logic             sat;

    // Next value and saturation flag
    always_comb begin
        cnt_inc = cnt_q + CNT_W'(1);
        sat     = &cnt_q;
    end

    // Limit register
    always_ff @(posedge clk) begin
        if (!rst_n)      thr_q <= THR_RST;
        else if (thr_wr) thr_q <= wdata;
    end

    // Tally update and single-cycle event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            evt   <= 1'b0;
        end else begin
            evt <= 1'b0;
            if (cnt_wr) begin
                cnt_q <= wdata;
            end else if (err && !sat) begin
                cnt_q <= cnt_inc;
                evt   <= (cnt_inc == thr_q) && (thr_q != '0);
            end
        end
    end
endmodule

// File: rtl/link_err_counters.sv
// Top level: three link error tallies behind one register window, each
// feeding its own threshold event bit. Reads are combinational.
module link_err_counters
    import lec_pkg::*;
#(
    parameter int                CNT_W    = LEC_CNT_W,
    parameter int                NUM_CNT  = LEC_NUM,
    parameter int                ADDR_W   = LEC_ADDR_W,
    parameter logic [ADDR_W-1:0] WIN_BASE = LEC_WIN_BASE,
    parameter logic [CNT_W-1:0]  THR_RST  = LEC_THR_RST
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [CNT_W-1:0]   rd_data,
    input  logic [NUM_CNT-1:0] err_pulse,
    output logic [NUM_CNT-1:0] thr_evt
);
    logic [NUM_CNT-1:0]            wr_cnt_sel, wr_thr_sel;
    logic [NUM_CNT-1:0]            rd_cnt_sel, rd_thr_sel;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all, thr_all;

    lec_regdec #(.NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_wdec (
        .en(wr_en), .addr(wr_addr), .cnt_sel(wr_cnt_sel), .thr_sel(wr_thr_sel)
    );

    lec_regdec #(.NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_rdec (
        .en(1'b1), .addr(rd_addr), .cnt_sel(rd_cnt_sel), .thr_sel(rd_thr_sel)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        lec_counter #(.CNT_W(CNT_W), .THR_RST(THR_RST)) u_cnt (
            .clk(clk), .rst_n(rst_n),
            .cnt_wr(wr_cnt_sel[i]), .thr_wr(wr_thr_sel[i]),
            .wdata(wr_data), .err(err_pulse[i]),
            .cnt_q(cnt_all[i]), .thr_q(thr_all[i]), .evt(thr_evt[i])
        );
    end

    // Read multiplexer; unmatched addresses return zero
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (rd_cnt_sel[i]) rd_data = cnt_all[i];
            if (rd_thr_sel[i]) rd_data = thr_all[i];
        end
    end
endmodule

// File: rtl/lec_chk.sv
// Checker for link_err_counters, attached by bind. Observes the write
// selects from the decoder and the tally/limit registers of each counter.
module lec_chk #(
    parameter int               CNT_W   = 16,
    parameter int               NUM_CNT = 3,
    parameter logic [CNT_W-1:0] THR_RST = 16'h8000
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_CNT-1:0]              err_pulse,
    input logic [NUM_CNT-1:0]              thr_evt,
    input logic [NUM_CNT-1:0]              cnt_wr,
    input logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_all,
    input logic [NUM_CNT-1:0][CNT_W-1:0]   thr_all
);
    logic past_ok;
    logic clk_seen;

    // Marks cycles whose previous cycle was out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Marks that at least one edge has been sampled
    always_ff @(posedge clk) clk_seen <= 1'b1;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
        assert_reset_R1: assert property (@(posedge clk)
            (clk_seen === 1'b1) && !$past(rst_n) |->
            (cnt_all[i] == '0) && (thr_all[i] == THR_RST) && !thr_evt[i]);

        assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && !$past(cnt_wr[i]) |->
            (cnt_all[i] == $past(cnt_all[i])) ||
            (cnt_all[i] == CNT_W'($past(cnt_all[i]) + 1'b1)));

        assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && !$past(cnt_wr[i]) && ($past(cnt_all[i]) == '1) |->
            (cnt_all[i] == '1));

        assert_evt_at_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && thr_evt[i] |-> (cnt_all[i] == $past(thr_all[i])));

        assert_evt_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && thr_evt[i] |-> $past(err_pulse[i]) && !$past(cnt_wr[i]));

        assert_wr_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && $past(cnt_wr[i]) |-> !thr_evt[i]);

        assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && !$past(err_pulse[i]) && !$past(cnt_wr[i]) |->
            $stable(cnt_all[i]));
    end
endmodule

bind link_err_counters lec_chk #(
    .CNT_W(CNT_W), .NUM_CNT(NUM_CNT), .THR_RST(THR_RST)
) u_chk (
    .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .thr_evt(thr_evt),
    .cnt_wr(wr_cnt_sel), .cnt_all(cnt_all), .thr_all(thr_all)
);

// File: tb/link_err_counters_tb.sv
module link_err_counters_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic [2:0]  err_pulse = '0;
    logic [2:0]  thr_evt;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    link_err_counters u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .err_pulse(err_pulse), .thr_evt(thr_evt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Vector: {req, wr, waddr, wdata, err, raddr, exp_rd, exp_evt}
    localparam logic [66:0] VEC [NV] = '{
        {4'd2, 1'b1, 12'h042, 16'h0003, 3'b000, 12'h042, 16'h0003, 3'b000}, // R2 decode limit=3
        {4'd3, 1'b0, 12'h000, 16'h0000, 3'b001, 12'h040, 16'h0001, 3'b000}, // R3
        {4'd3, 1'b0, 12'h000, 16'h0000, 3'b001, 12'h040, 16'h0002, 3'b000}, // R3
        {4'd5, 1'b0, 12'h000, 16'h0000, 3'b001, 12'h040, 16'h0003, 3'b001}, // R5 reach limit
        {4'd5, 1'b0, 12'h000, 16'h0000, 3'b001, 12'h040, 16'h0004, 3'b000}, // R5 past limit
        {4'd8, 1'b0, 12'h000, 16'h0000, 3'b000, 12'h044, 16'h0000, 3'b000}, // R8 CRC untouched
        {4'd2, 1'b1, 12'h046, 16'h0001, 3'b000, 12'h046, 16'h0001, 3'b000}, // R2 CRC limit=1
        {4'd5, 1'b0, 12'h000, 16'h0000, 3'b111, 12'h044, 16'h0001, 3'b010}, // R5 only CRC fires
        {4'd8, 1'b0, 12'h000, 16'h0000, 3'b000, 12'h048, 16'h0001, 3'b000}, // R8
        {4'd2, 1'b1, 12'h04A, 16'h0000, 3'b000, 12'h04A, 16'h0000, 3'b000}, // R2 hs limit=0
        {4'd7, 1'b1, 12'h048, 16'hFFFE, 3'b100, 12'h048, 16'hFFFE, 3'b000}, // R7 write wins
        {4'd6, 1'b0, 12'h000, 16'h0000, 3'b100, 12'h048, 16'hFFFF, 3'b000}, // R6 zero limit
        {4'd4, 1'b0, 12'h000, 16'h0000, 3'b100, 12'h048, 16'hFFFF, 3'b000}, // R4 saturate
        {4'd2, 1'b1, 12'h04A, 16'hFFFF, 3'b000, 12'h04A, 16'hFFFF, 3'b000}, // R2 hs limit=FFFF
        {4'd4, 1'b0, 12'h000, 16'h0000, 3'b100, 12'h048, 16'hFFFF, 3'b000}, // R4 no event at sat
        {4'd7, 1'b1, 12'h040, 16'h0002, 3'b001, 12'h040, 16'h0002, 3'b000}, // R7 write wins
        {4'd5, 1'b0, 12'h000, 16'h0000, 3'b001, 12'h040, 16'h0003, 3'b001}, // R5
        {4'd2, 1'b1, 12'h041, 16'h1234, 3'b000, 12'h040, 16'h0003, 3'b000}, // R2 odd address
        {4'd2, 1'b1, 12'h04C, 16'h0005, 3'b000, 12'h04C, 16'h0000, 3'b000}, // R2 outside window
        {4'd7, 1'b1, 12'h044, 16'h0001, 3'b000, 12'h044, 16'h0001, 3'b000}, // R7 write = limit
        {4'd4, 1'b1, 12'h048, 16'hFFFE, 3'b000, 12'h048, 16'hFFFE, 3'b000}, // R4 preload
        {4'd5, 1'b0, 12'h000, 16'h0000, 3'b100, 12'h048, 16'hFFFF, 3'b100}  // R5 top limit
    };

    task automatic check(input int req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic read_check(input int req, input logic [11:0] a, input logic [15:0] exp);
        rd_addr = a;
        #1;
        check(req, $sformatf("read %h", a), rd_data, exp);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        read_check(1, 12'h040, 16'h0000);
        read_check(1, 12'h042, 16'h8000);
        read_check(1, 12'h044, 16'h0000);
        read_check(1, 12'h046, 16'h8000);
        read_check(1, 12'h048, 16'h0000);
        read_check(1, 12'h04A, 16'h8000);
        check(1, "event after reset", {13'd0, thr_evt}, 16'h0000);

        for (int v = 0; v < NV; v++) begin
            wr_en     = VEC[v][62];
            wr_addr   = VEC[v][61:50];
            wr_data   = VEC[v][49:34];
            err_pulse = VEC[v][33:31];
            rd_addr   = VEC[v][30:19];
            @(posedge clk);
            @(negedge clk);
            wr_en     = 1'b0;
            err_pulse = '0;
            check(int'(VEC[v][66:63]), $sformatf("vector %0d read", v), rd_data, VEC[v][18:3]);
            check(int'(VEC[v][66:63]), $sformatf("vector %0d event", v),
                  {13'd0, thr_evt}, {13'd0, VEC[v][2:0]});
        end

        // R5: single pulse, event drops the following cycle
        @(negedge clk);
        check(5, "event held low", {13'd0, thr_evt}, 16'h0000);

        // R1: reset in mid-run restores defaults
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_check(1, 12'h040, 16'h0000);
        read_check(1, 12'h046, 16'h8000);
        read_check(1, 12'h048, 16'h0000);
        read_check(1, 12'h04A, 16'h8000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule